// File: doc/BRIEF.md
# Multi-Source XOR and Fill Engine

This engine builds one destination buffer out of up to eight source buffers, one data word at a time. A single start pulse hands it a complete job: a 32-bit control word, eight source base addresses, a destination base address and a length in words. The control word packs one 3-bit command for each source. The commands are direct load, XOR-accumulate, constant fill or unused. For every word position the engine visits the enabled sources in ascending index order and folds each source into an accumulator. It then writes the result to the destination, or only tests it for zero.

The memory side has two ports. The read port has a fixed latency of one cycle: data appears on the cycle after the request. The write port takes one word per cycle. When the job ends, the engine returns the control word with its completion bit and its zero-error bit updated, and pulses done. It can also raise an interrupt pulse. A job in check mode has a length limit of 1024 bytes. A job in normal mode has a limit of 16 MiB. Longer requests are cut to the limit.

Top module: `xfe_engine`

## Requirements
- R1: After reset, busy, done, irq, rd_en and wr_en are all 0.
- R2: Control word bits [3k+3:3k+1] hold the command of source k. For each word w, command 111 on source 0 loads mem[src0+w] into the accumulator. Command 001 XORs mem[srck+w] into it. With bit 31 set, the result is written to dst+w.
- R3: A source with command 000 is never read and has no effect on the result. When source 0 has command 001, accumulation starts from zero.
- R4: Command 010 on source 0 is a fill. The accumulator takes the value of source address word 0 without any memory read. Later sources with command 001 are still XORed in.
- R5: When block-size bits [26:25] are 00, the commands of sources 4 to 7 are ignored. Any other value enables all eight sources.
- R6: On sources 1 to 7, any command other than 001 counts as unused. On source 0, any command other than 001, 010 or 111 counts as unused.
- R7: When bit 31 is clear, no destination write takes place, so destination memory keeps its contents.
- R8: When bit 30 is set, control-word bit 29 is written back as 1 if any result word was non-zero, and as 0 otherwise. When bit 30 is clear, bit 29 is written back as 0.
- R9: When bit 30 is set, the word count is limited to 1024 bytes, which is 256 words of 32 bits.
- R10: done is a one-cycle pulse. ctl_out then equals the input control word with bit 28 set and bit 29 set as in R8. irq pulses together with done only when bit 0 is set.
- R11: A start pulse that arrives while busy is 1 is ignored.
- R12: A word count of 0 completes the job with no memory reads and no memory writes.
- R13: Within one word, sources are read in ascending index order. The destination word is written after the last source has been read, and a read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a job when idle |
| ctl_in | input | 32 | Job control word |
| src_addr | input | NSRC*AW | Source base addresses, source k at bits [k*AW +: AW] |
| dst_addr | input | AW | Destination base address |
| word_cnt | input | LEN_W | Job length in words |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW | Read word address |
| rd_data | input | DW | Read data, one cycle after rd_en |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Write word address |
| wr_data | output | DW | Write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt pulse |
| ctl_out | output | 32 | Written-back control word |

## Verification
The bench uses the default parameters: 32-bit data and addresses, and a 23-bit length. This makes the 256-word check limit small enough to exercise directly. The test places non-zero data just beyond that limit and confirms it never reaches the zero test. The bench keeps a 1024-word memory, so each of the eight sources gets its own area and the destination sits in a separate area. This lets every command combination, the block-size masking and the ascending read order be observed directly through the read addresses and the memory contents.

// File: rtl/xfe_pkg.sv
package xfe_pkg;
   localparam int NSRC = 8;
   localparam int CW   = 32;

   localparam int IRQ_BIT  = 0;
   localparam int BLK_LO   = 25;
   localparam int DONE_BIT = 28;
   localparam int ZERR_BIT = 29;
   localparam int ZCHK_BIT = 30;
   localparam int WEN_BIT  = 31;

   localparam logic [2:0] CMD_XOR  = 3'b001;
   localparam logic [2:0] CMD_FILL = 3'b010;
   localparam logic [2:0] CMD_LOAD = 3'b111;

   typedef enum logic [1:0] {ACT_SKIP, ACT_XOR, ACT_LOAD, ACT_FILL} src_act_t;
   typedef enum logic [1:0] {ACC_HOLD, ACC_CLEAR, ACC_LOAD, ACC_XOR} acc_op_t;

   typedef struct packed {
      src_act_t [NSRC-1:0] act;
      logic [NSRC-1:0]     active;
      logic                irq_en;
      logic                zchk;
      logic                wen;
   } dec_t;
endpackage

// File: rtl/xfe_ctl_decode.sv
module xfe_ctl_decode
   import xfe_pkg::*;
(
   input  logic [CW-1:0] ctl,
   output dec_t          dec
);
   localparam int SMALL_SRC = 4;

   src_act_t act_w [NSRC];
   logic     wide;
   logic     unused_bits;

   assign wide        = ctl[BLK_LO +: 2] != 2'b00;
   assign unused_bits = ^ctl[ZERR_BIT:BLK_LO+2];

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic [2:0] cmd;
      src_act_t   raw;
      assign cmd = ctl[3*k+1 +: 3];
      if (k == 0) begin : g_lead
         always_comb begin
            case (cmd)
               CMD_XOR:  raw = ACT_XOR;
               CMD_LOAD: raw = ACT_LOAD;
               CMD_FILL: raw = ACT_FILL;
               default:  raw = ACT_SKIP;
            endcase
         end
      end else begin : g_follow
         assign raw = (cmd == CMD_XOR) ? ACT_XOR : ACT_SKIP;
      end
      if (k < SMALL_SRC) begin : g_base
         assign act_w[k] = raw;
      end else begin : g_wide
         assign act_w[k] = wide ? raw : ACT_SKIP;
      end
   end

   always_comb begin
      dec.irq_en = ctl[IRQ_BIT];
      dec.zchk   = ctl[ZCHK_BIT];
      dec.wen    = ctl[WEN_BIT];
      for (int k = 0; k < NSRC; k++) begin
         dec.act[k]    = act_w[k];
         dec.active[k] = act_w[k] != ACT_SKIP;
      end
   end
endmodule

// File: rtl/xfe_accum.sv
module xfe_accum
   import xfe_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  acc_op_t       op,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else begin
         case (op)
            ACC_CLEAR: acc <= '0;
            ACC_LOAD:  acc <= din;
            ACC_XOR:   acc <= acc ^ din;
            default:   acc <= acc;
         endcase
      end
   end
endmodule

// File: rtl/xfe_seq.sv
module xfe_seq
   import xfe_pkg::*;
#(
   parameter int DW          = 32,
   parameter int AW          = 32,
   parameter int LEN_W       = 23,
   parameter int CHECK_WORDS = 256,
   parameter int XOR_WORDS   = 4194304
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CW-1:0]      ctl_in,
   input  logic [NSRC*AW-1:0] src_in,
   input  logic [AW-1:0]      dst_in,
   input  logic [LEN_W-1:0]   cnt_in,
   input  dec_t               dec,
   input  logic [DW-1:0]      acc,
   input  logic [DW-1:0]      rd_data,
   output logic [CW-1:0]      ctl_q,
   output logic               rd_en,
   output logic [AW-1:0]      rd_addr,
   output logic               wr_en,
   output logic [AW-1:0]      wr_addr,
   output logic [DW-1:0]      wr_data,
   output acc_op_t            acc_op,
   output logic [DW-1:0]      acc_din,
   output logic               busy,
   output logic               done,
   output logic               irq,
   output logic [CW-1:0]      ctl_out
);
   localparam int KW = $clog2(NSRC);

   typedef enum logic [2:0] {S_IDLE, S_LAUNCH, S_STEP, S_WAIT, S_RESULT, S_FIN} st_t;

   st_t              st, st_n;
   logic [CW-1:0]    ctl_r, ctl_out_r;
   logic [AW-1:0]    src_r [NSRC];
   logic [AW-1:0]    dst_r;
   logic [LEN_W-1:0] words_r, w_r, w_n, words_cap;
   logic [KW-1:0]    k_r, k_n;
   logic             zerr_r, zerr_n, done_r, irq_r;
   logic [DW-1:0]    fill_r, fill_w;
   logic [NSRC-1:0]  hi_mask;
   logic [KW:0]      first_all, next_up;
   logic             adv;

   if (AW >= DW) begin : g_fill_trunc
      assign fill_w = src_in[DW-1:0];
   end else begin : g_fill_ext
      assign fill_w = {{(DW-AW){1'b0}}, src_in[AW-1:0]};
   end

   function automatic logic [KW:0] first_of(input logic [NSRC-1:0] m);
      logic [KW:0] r;
      r = '0;
      for (int i = NSRC-1; i >= 0; i--)
         if (m[i]) r = {1'b1, KW'(i)};
      return r;
   endfunction

   always_comb begin
      if (ctl_in[ZCHK_BIT] && cnt_in > LEN_W'(CHECK_WORDS))
         words_cap = LEN_W'(CHECK_WORDS);
      else if (cnt_in > LEN_W'(XOR_WORDS))
         words_cap = LEN_W'(XOR_WORDS);
      else
         words_cap = cnt_in;
   end

   always_comb begin
      for (int i = 0; i < NSRC; i++) hi_mask[i] = i > int'(k_r);
      first_all = first_of(dec.active);
      next_up   = first_of(dec.active & hi_mask);
   end

   always_comb begin
      st_n    = st;
      k_n     = k_r;
      w_n     = w_r;
      zerr_n  = zerr_r;
      rd_en   = 1'b0;
      wr_en   = 1'b0;
      acc_op  = ACC_HOLD;
      acc_din = rd_data;
      adv     = 1'b0;
      case (st)
         S_LAUNCH: begin
            acc_op = ACC_CLEAR;
            w_n    = '0;
            if (words_r == '0) begin
               st_n = S_FIN;
            end else if (!first_all[KW]) begin
               st_n = S_RESULT;
            end else begin
               k_n  = first_all[KW-1:0];
               st_n = S_STEP;
            end
         end
         S_STEP: begin
            if (dec.act[k_r] == ACT_FILL) begin
               acc_op  = ACC_LOAD;
               acc_din = fill_r;
               adv     = 1'b1;
            end else begin
               rd_en = 1'b1;
               st_n  = S_WAIT;
            end
         end
         S_WAIT: begin
            acc_op = (dec.act[k_r] == ACT_LOAD) ? ACC_LOAD : ACC_XOR;
            adv    = 1'b1;
         end
         S_RESULT: begin
            wr_en  = dec.wen;
            acc_op = ACC_CLEAR;
            w_n    = w_r + 1'b1;
            if (dec.zchk && acc != '0) zerr_n = 1'b1;
            if (w_n == words_r) begin
               st_n = S_FIN;
            end else if (first_all[KW]) begin
               k_n  = first_all[KW-1:0];
               st_n = S_STEP;
            end else begin
               st_n = S_RESULT;
            end
         end
         S_FIN:   st_n = S_IDLE;
         default: st_n = S_IDLE;
      endcase
      if (adv) begin
         if (next_up[KW]) begin
            k_n  = next_up[KW-1:0];
            st_n = S_STEP;
         end else begin
            st_n = S_RESULT;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         ctl_r     <= '0;
         ctl_out_r <= '0;
         dst_r     <= '0;
         words_r   <= '0;
         w_r       <= '0;
         k_r       <= '0;
         zerr_r    <= 1'b0;
         done_r    <= 1'b0;
         irq_r     <= 1'b0;
         fill_r    <= '0;
         for (int i = 0; i < NSRC; i++) src_r[i] <= '0;
      end else begin
         st     <= st_n;
         k_r    <= k_n;
         w_r    <= w_n;
         zerr_r <= zerr_n;
         done_r <= 1'b0;
         irq_r  <= 1'b0;
         if (st == S_IDLE && start) begin
            ctl_r   <= ctl_in;
            dst_r   <= dst_in;
            words_r <= words_cap;
            fill_r  <= fill_w;
            zerr_r  <= 1'b0;
            st      <= S_LAUNCH;
            for (int i = 0; i < NSRC; i++) src_r[i] <= src_in[i*AW +: AW];
         end
         if (st == S_FIN) begin
            done_r    <= 1'b1;
            irq_r     <= dec.irq_en;
            ctl_out_r <= ctl_r;
            ctl_out_r[DONE_BIT] <= 1'b1;
            ctl_out_r[ZERR_BIT] <= zerr_r;
         end
      end
   end

   assign ctl_q   = ctl_r;
   assign rd_addr = src_r[k_r] + AW'(w_r);
   assign wr_addr = dst_r + AW'(w_r);
   assign wr_data = acc;
   assign busy    = st != S_IDLE;
   assign done    = done_r;
   assign irq     = irq_r;
   assign ctl_out = ctl_out_r;

   // R11: a start while a job runs leaves the captured control word alone
   p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && start) |=> $stable(ctl_r));

   // R10: completion is a single-cycle pulse
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: a check-mode job never runs past the check limit
   p_check_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_LAUNCH && ctl_r[ZCHK_BIT]) |-> (words_r <= LEN_W'(CHECK_WORDS)));
endmodule

// File: rtl/xfe_engine.sv
module xfe_engine
   import xfe_pkg::*;
#(
   parameter int DW              = 32,
   parameter int AW              = 32,
   parameter int LEN_W           = 23,
   parameter int CHECK_MAX_BYTES = 1024,
   parameter int XOR_MAX_BYTES   = 16777216
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [31:0]        ctl_in,
   input  logic [NSRC*AW-1:0] src_addr,
   input  logic [AW-1:0]      dst_addr,
   input  logic [LEN_W-1:0]   word_cnt,
   output logic               rd_en,
   output logic [AW-1:0]      rd_addr,
   input  logic [DW-1:0]      rd_data,
   output logic               wr_en,
   output logic [AW-1:0]      wr_addr,
   output logic [DW-1:0]      wr_data,
   output logic               busy,
   output logic               done,
   output logic               irq,
   output logic [31:0]        ctl_out
);
   localparam int BPW         = DW / 8;
   localparam int CHECK_WORDS = CHECK_MAX_BYTES / BPW;
   localparam int XOR_WORDS   = XOR_MAX_BYTES / BPW;

   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("xfe_engine: DW must be a whole number of bytes");
   end
   if (CHECK_MAX_BYTES % BPW != 0 || XOR_MAX_BYTES % BPW != 0) begin : g_bad_lim
      $error("xfe_engine: byte limits must be whole words");
   end
   if (XOR_WORDS >= 2**LEN_W || CHECK_WORDS > XOR_WORDS) begin : g_bad_len
      $error("xfe_engine: LEN_W too narrow for the length limits");
   end

   dec_t          dec;
   logic [CW-1:0] ctl_q;
   acc_op_t       acc_op;
   logic [DW-1:0] acc_din, acc;

   xfe_seq #(
      .DW(DW), .AW(AW), .LEN_W(LEN_W),
      .CHECK_WORDS(CHECK_WORDS), .XOR_WORDS(XOR_WORDS)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ctl_in(ctl_in),
      .src_in(src_addr), .dst_in(dst_addr), .cnt_in(word_cnt),
      .dec(dec), .acc(acc), .rd_data(rd_data), .ctl_q(ctl_q),
      .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .acc_op(acc_op), .acc_din(acc_din),
      .busy(busy), .done(done), .irq(irq), .ctl_out(ctl_out)
   );

   xfe_ctl_decode i_dec (.ctl(ctl_q), .dec(dec));

   xfe_accum #(.DW(DW)) i_acc (
      .clk(clk), .rst_n(rst_n), .op(acc_op), .din(acc_din), .acc(acc)
   );

   // R13: memory read and write never share a cycle
   p_rw_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));

   // R7: a write needs the destination-write bit of the running job
   p_write_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> dec.wen);

   // R10: the interrupt pulse only comes with completion
   p_irq_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);
endmodule

// File: tb/test_xfe_engine.sv
module test_xfe_engine;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 23;
   localparam logic [31:0] WEN  = 32'h8000_0000;
   localparam logic [31:0] ZCHK = 32'h4000_0000;
   localparam logic [31:0] BLK8 = 32'h0200_0000;
   localparam logic [31:0] IRQE = 32'h0000_0001;
   localparam int DST = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] ctl_in = '0;
   logic [8*AW-1:0] src_addr = '0;
   logic [AW-1:0] dst_addr = AW'(DST);
   logic [LW-1:0] word_cnt = '0;
   logic rd_en, wr_en, busy, done, irq;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0] rd_data, wr_data;
   logic [31:0] ctl_out;

   logic [31:0] mem [0:1023];
   int n_checks = 0, n_fail = 0;
   int rd_cnt, wr_cnt, done_cnt, log_n;
   logic [31:0] rd_log [0:15];
   logic [31:0] last_ctl;
   logic last_irq;

   always #2.5 clk = ~clk;

   xfe_engine i_xfe_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .ctl_in(ctl_in),
      .src_addr(src_addr), .dst_addr(dst_addr), .word_cnt(word_cnt),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done), .irq(irq), .ctl_out(ctl_out)
   );

   always @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_addr[9:0]];
      if (wr_en) mem[wr_addr[9:0]] <= wr_data;
   end

   always @(negedge clk) begin
      if (rd_en) begin
         if (log_n < 16) rd_log[log_n] <= rd_addr;
         log_n  <= log_n + 1;
         rd_cnt <= rd_cnt + 1;
      end
      if (wr_en) wr_cnt <= wr_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] cmd(input int k, input logic [2:0] c);
      return 32'(c) << (3*k + 1);
   endfunction

   function automatic logic [31:0] base(input int k);
      return src_addr[32*k +: 32];
   endfunction

   function automatic logic [31:0] exp_word(input logic [31:0] c, input int w);
      logic [31:0] a = '0;
      for (int k = 0; k < 8; k++) begin
         logic [2:0] cm = c[3*k+1 +: 3];
         logic [31:0] d = mem[10'(base(k) + 32'(w))];
         if (k >= 4 && c[26:25] == 2'b00) continue;
         if (k == 0) begin
            if (cm == 3'b111) a = d;
            else if (cm == 3'b001) a = a ^ d;
            else if (cm == 3'b010) a = base(0);
         end else if (cm == 3'b001) a = a ^ d;
      end
      return a;
   endfunction

   task automatic init_mem;
      for (int i = 0; i < 1024; i++)
         mem[i] = (i < DST) ? (32'(i) * 32'h9E37_79B1 + 32'h0123_4567) : (32'hDEAD_0000 | 32'(i));
      for (int k = 0; k < 8; k++) src_addr[32*k +: 32] = 32'(64*k);
   endtask

   task automatic run(input logic [31:0] c, input int n, input bit interfere);
      int t;
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; done_cnt = 0; log_n = 0;
      ctl_in = c; word_cnt = LW'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (interfere) begin
         repeat (8) @(negedge clk);
         ctl_in = WEN | cmd(0, 3'b010);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (!done && t < 5000) begin
         @(negedge clk);
         t++;
      end
      if (!done) chk("timeout", 32'(t), 32'd0);
      last_ctl = ctl_out;
      last_irq = irq;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_dest(input string req, input logic [31:0] c, input int n);
      for (int w = 0; w < n; w++) chk(req, mem[DST + w], exp_word(c, w));
   endtask

   task automatic t_reset;
      chk("R1 busy", 32'(busy), 0);
      chk("R1 done", 32'(done), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 rd_en", 32'(rd_en), 0);
      chk("R1 wr_en", 32'(wr_en), 0);
   endtask

   task automatic t_xor_basic;
      logic [31:0] c = WEN | BLK8 | IRQE | cmd(0, 3'b111) | cmd(1, 3'b001) | cmd(2, 3'b001) | cmd(3, 3'b001);
      init_mem();
      run(c, 16, 1'b0);
      check_dest("R2 xor", c, 16);
      chk("R2 writes", 32'(wr_cnt), 16);
      chk("R10 ctl_out", last_ctl, c | 32'h1000_0000);
      chk("R10 irq", 32'(last_irq), 1);
      chk("R10 done pulses", 32'(done_cnt), 1);
   endtask

   task automatic t_skip;
      logic [31:0] c = WEN | BLK8 | cmd(0, 3'b001) | cmd(2, 3'b001) | cmd(3, 3'b111)
                       | cmd(4, 3'b010) | cmd(5, 3'b001) | cmd(6, 3'b110);
      init_mem();
      run(c, 8, 1'b0);
      check_dest("R3 R6 skip", c, 8);
      chk("R3 first word", mem[DST], mem[0] ^ mem[128] ^ mem[320]);
      chk("R6 reads", 32'(rd_cnt), 24);
      chk("R10 no irq", 32'(last_irq), 0);
   endtask

   task automatic t_blk4;
      logic [31:0] c = WEN | cmd(0, 3'b111) | cmd(1, 3'b001) | cmd(5, 3'b001) | cmd(6, 3'b001);
      init_mem();
      run(c, 8, 1'b0);
      chk("R5 word0", mem[DST], mem[0] ^ mem[64]);
      check_dest("R5 blk4", c, 8);
      chk("R5 reads", 32'(rd_cnt), 16);
   endtask

   task automatic t_fill;
      logic [31:0] c = WEN | cmd(0, 3'b010);
      init_mem();
      src_addr[31:0] = 32'hCAFE_F00D;
      run(c, 10, 1'b0);
      for (int w = 0; w < 10; w++) chk("R4 fill", mem[DST + w], 32'hCAFE_F00D);
      chk("R4 no reads", 32'(rd_cnt), 0);
      c = c | cmd(2, 3'b001);
      run(c, 6, 1'b0);
      check_dest("R4 fill xor", c, 6);
      chk("R4 fill xor reads", 32'(rd_cnt), 6);
   endtask

   task automatic t_order;
      logic [31:0] c = WEN | BLK8 | cmd(0, 3'b111) | cmd(2, 3'b001) | cmd(7, 3'b001);
      logic [31:0] exp_seq [6] = '{32'd0, 32'd128, 32'd448, 32'd1, 32'd129, 32'd449};
      init_mem();
      run(c, 2, 1'b0);
      for (int i = 0; i < 6; i++) chk("R13 read order", rd_log[i], exp_seq[i]);
      check_dest("R13 result", c, 2);
   endtask

   task automatic t_nowrite;
      logic [31:0] c = BLK8 | cmd(0, 3'b111) | cmd(1, 3'b001) | 32'h2000_0000;
      init_mem();
      run(c, 8, 1'b0);
      chk("R7 writes", 32'(wr_cnt), 0);
      for (int w = 0; w < 8; w++) chk("R7 dest kept", mem[DST + w], 32'hDEAD_0000 | 32'(DST + w));
      chk("R8 R10 ctl_out", last_ctl, (c | 32'h1000_0000) & ~32'h2000_0000);
   endtask

   task automatic t_check;
      logic [31:0] c = ZCHK | cmd(0, 3'b111) | cmd(1, 3'b001);
      init_mem();
      for (int i = 0; i < 8; i++) mem[64 + i] = mem[i];
      run(c, 8, 1'b0);
      chk("R8 zero ok", last_ctl, c | 32'h1000_0000);
      chk("R8 no writes", 32'(wr_cnt), 0);
      mem[69] = mem[69] ^ 32'h10;
      run(c, 8, 1'b0);
      chk("R8 zero err", last_ctl, c | 32'h3000_0000);
   endtask

   task automatic t_clamp;
      logic [31:0] c = ZCHK | cmd(0, 3'b111);
      init_mem();
      for (int i = 0; i < 300; i++) mem[i] = (i < 256) ? 32'd0 : 32'd1;
      run(c, 300, 1'b0);
      chk("R9 reads", 32'(rd_cnt), 256);
      chk("R9 no err", last_ctl, c | 32'h1000_0000);
      mem[255] = 32'd7;
      run(c, 256, 1'b0);
      chk("R9 last word seen", last_ctl, c | 32'h3000_0000);
   endtask

   task automatic t_busy_start;
      logic [31:0] c = WEN | cmd(0, 3'b111) | cmd(1, 3'b001);
      init_mem();
      run(c, 32, 1'b1);
      check_dest("R11 first job kept", c, 32);
      chk("R11 ctl_out", last_ctl, c | 32'h1000_0000);
      chk("R11 one done", 32'(done_cnt), 1);
      chk("R11 idle after", 32'(busy), 0);
   endtask

   task automatic t_zero_len;
      logic [31:0] c = WEN | cmd(0, 3'b111);
      init_mem();
      run(c, 0, 1'b0);
      chk("R12 reads", 32'(rd_cnt), 0);
      chk("R12 writes", 32'(wr_cnt), 0);
      chk("R12 done", 32'(done_cnt), 1);
      chk("R12 ctl_out", last_ctl, c | 32'h1000_0000);
   endtask

   initial begin
      #(100000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      rd_cnt = 0; wr_cnt = 0; done_cnt = 0; log_n = 0;
      init_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_xor_basic();
      t_skip();
      t_blk4();
      t_fill();
      t_order();
      t_nowrite();
      t_check();
      t_clamp();
      t_busy_start();
      t_zero_len();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule